// File: doc/BRIEF.md
# Memory Access Fault Detector

This block watches three kinds of activity on a processor core: data-space accesses, instruction fetches and stack pointer loads. It reports violations to the trap controller on two flags. The address-error flag collects every addressing fault into one source. These faults are a misaligned word access, a data access outside the implemented data or program ranges, a fetch from the vector table region, a split-space violation during a multiply-accumulate operand fetch, and a fetch that follows a jump, branch or return to an unimplemented program address. The stack-error flag reports a stack pointer load above a software-programmed ceiling, or below a fixed floor.

All implemented ranges are parameters. The flags are registered, so a fault seen in one cycle shows up as a one-cycle pulse after the next rising clock edge. A pending bad jump target is tracked by a two-state machine. In state `ST_RUN` no target fault is pending. A program-counter load to an unimplemented address moves it to `ST_BAD_TARGET`. From there, the next fetch raises the fault and returns the machine to `ST_RUN`. A later program-counter load to a valid address also returns it to `ST_RUN`, with no fault. A further bad load keeps it in `ST_BAD_TARGET`.

Top module: `mem_fault_det`

## Requirements
- R1: A word access (`acc_word`=1) with a read or write strobe to an odd address (bit 0 set) raises `addr_err`. A byte access (`acc_word`=0) never raises it for alignment.
- R2: A non-multiply-accumulate data access (`acc_pspace`=0, `mac_op`=0) above `DATA_LAST` (default 0x1FFF) raises `addr_err`. Addresses 0 to `DATA_LAST` do not.
- R3: A data access marked as program space (`acc_pspace`=1) above `PROG_LAST` (default 0x00AFFF) raises `addr_err`. Addresses up to `PROG_LAST` do not.
- R4: A fetch (`fetch_valid`=1) whose address lies in `VEC_FIRST`..`VEC_LAST` (default 0x000004..0x0000FF) raises `addr_err`. So does a fetch above `PROG_LAST`. Addresses 0..3 and 0x100..`PROG_LAST` are fault-free.
- R5: With `mac_op`=1, `mac_ysel`=0 selects X space (0 to `Y_FIRST`-1) and `mac_ysel`=1 selects Y space (`Y_FIRST` to `DATA_LAST`, default `Y_FIRST`=0x1000). An access outside the selected space raises `addr_err`.
- R6: A stack pointer load (`sp_load`=1) with `sp_value` strictly greater than the limit register raises `stack_err`. A value equal to the limit does not.
- R7: A stack pointer load with `sp_value` below `SP_FLOOR` (0x0800) raises `stack_err`. A load of exactly 0x0800 does not.
- R8: The limit register resets to all ones, so no load overflows until `lim_wr`=1 stores `lim_data`. The new limit governs loads from the next cycle on.
- R9: A `pc_load` with `pc_target` above `PROG_LAST` enters `ST_BAD_TARGET` and raises no flag by itself. The next fetch raises `addr_err` and returns the machine to `ST_RUN`. A valid `pc_load` before that fetch cancels the pending fault.
- R10: Both flags are 0 after reset. Each flag rises one clock after the faulting cycle and lasts one cycle per faulting cycle. Both stay 0 when no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_rd | input | 1 | Data read strobe |
| acc_wr | input | 1 | Data write strobe |
| acc_word | input | 1 | 1 = word access, 0 = byte access |
| acc_pspace | input | 1 | 1 = access targets program memory |
| acc_addr | input | AW (24) | Byte address of the data access |
| mac_op | input | 1 | Access is a multiply-accumulate operand fetch |
| mac_ysel | input | 1 | 0 = X space, 1 = Y space |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | AW (24) | Instruction fetch address |
| pc_load | input | 1 | Program counter loaded by a jump, branch or return |
| pc_target | input | AW (24) | New program counter value |
| sp_load | input | 1 | Stack pointer load strobe |
| sp_value | input | SPW (16) | Value loaded into the stack pointer |
| lim_wr | input | 1 | Write strobe for the stack limit register |
| lim_data | input | SPW (16) | New stack limit |
| addr_err | output | 1 | Registered address-error pulse |
| stack_err | output | 1 | Registered stack-error pulse |

## Verification
Data accesses are driven at each side of every range edge: `DATA_LAST`, `PROG_LAST`, `Y_FIRST`, and both ends of the vector region. This separates an off-by-one comparison from a correct one. Word and byte accesses at the same odd address separate the alignment rule from the range rules. Identical addresses with the X and Y selects swapped show that the split-space check follows the select. Stack loads at the floor, one below it, at the limit and one above it are made both before and after a limit write, which confirms the reset limit. A bad jump target is followed by an unrelated fetch, or first by a valid jump target, to confirm that the fault is deferred to the fetch and can be cancelled.

// File: rtl/afd_pkg.sv
package afd_pkg;
    typedef enum logic [0:0] {
        ST_RUN        = 1'b0,
        ST_BAD_TARGET = 1'b1
    } pc_state_e;
endpackage

// File: rtl/afd_data_chk.sv
module afd_data_chk #(
    parameter int          AW        = 24,
    parameter logic [31:0] DATA_LAST = 32'h0000_1FFF,
    parameter logic [31:0] Y_FIRST   = 32'h0000_1000,
    parameter logic [31:0] PROG_LAST = 32'h0000_AFFF
) (
    input  logic          acc_rd,
    input  logic          acc_wr,
    input  logic          acc_word,
    input  logic          acc_pspace,
    input  logic          mac_op,
    input  logic          mac_ysel,
    input  logic [AW-1:0] acc_addr,
    output logic          fault
);
    localparam logic [AW-1:0] D_LAST = DATA_LAST[AW-1:0];
    localparam logic [AW-1:0] Y_LOW  = Y_FIRST[AW-1:0];
    localparam logic [AW-1:0] P_LAST = PROG_LAST[AW-1:0];

    logic active;
    logic misaligned;
    logic out_of_range;

    assign active     = acc_rd | acc_wr;
    assign misaligned = acc_word & acc_addr[0];

    always_comb begin
        if (acc_pspace)
            out_of_range = (acc_addr > P_LAST);
        else if (mac_op && mac_ysel)
            out_of_range = (acc_addr < Y_LOW) || (acc_addr > D_LAST);
        else if (mac_op)
            out_of_range = (acc_addr >= Y_LOW);
        else
            out_of_range = (acc_addr > D_LAST);
    end

    assign fault = active & (misaligned | out_of_range);
endmodule

// File: rtl/afd_fetch_fsm.sv
module afd_fetch_fsm
    import afd_pkg::*;
#(
    parameter int          AW        = 24,
    parameter logic [31:0] PROG_LAST = 32'h0000_AFFF,
    parameter logic [31:0] VEC_FIRST = 32'h0000_0004,
    parameter logic [31:0] VEC_LAST  = 32'h0000_00FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    input  logic          pc_load,
    input  logic [AW-1:0] pc_target,
    output logic          fault
);
    localparam logic [AW-1:0] P_LAST = PROG_LAST[AW-1:0];
    localparam logic [AW-1:0] V_LOW  = VEC_FIRST[AW-1:0];
    localparam logic [AW-1:0] V_HIGH = VEC_LAST[AW-1:0];

    pc_state_e state, state_nxt;
    logic      target_bad;
    logic      fetch_bad;

    assign target_bad = pc_target > P_LAST;
    assign fetch_bad  = ((fetch_addr >= V_LOW) && (fetch_addr <= V_HIGH))
                      || (fetch_addr > P_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (pc_load && target_bad) state_nxt = ST_BAD_TARGET;
            end
            ST_BAD_TARGET: begin
                if (pc_load)          state_nxt = target_bad ? ST_BAD_TARGET : ST_RUN;
                else if (fetch_valid) state_nxt = ST_RUN;
            end
            default: state_nxt = ST_RUN;
        endcase
    end

    always_comb begin
        fault = 1'b0;
        unique case (state)
            ST_RUN:        fault = fetch_valid & fetch_bad;
            ST_BAD_TARGET: fault = fetch_valid;
            default:       fault = 1'b0;
        endcase
    end
endmodule

// File: rtl/afd_stack_chk.sv
module afd_stack_chk #(
    parameter int          SPW      = 16,
    parameter logic [31:0] SP_FLOOR = 32'h0000_0800
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lim_wr,
    input  logic [SPW-1:0] lim_data,
    input  logic           sp_load,
    input  logic [SPW-1:0] sp_value,
    output logic           fault
);
    localparam logic [SPW-1:0] FLOOR = SP_FLOOR[SPW-1:0];

    logic [SPW-1:0] limit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      limit_q <= '1;
        else if (lim_wr) limit_q <= lim_data;
    end

    assign fault = sp_load & ((sp_value > limit_q) | (sp_value < FLOOR));
endmodule

// File: rtl/mem_fault_det.sv
module mem_fault_det #(
    parameter int          AW        = 24,
    parameter int          SPW       = 16,
    parameter logic [31:0] DATA_LAST = 32'h0000_1FFF,
    parameter logic [31:0] Y_FIRST   = 32'h0000_1000,
    parameter logic [31:0] PROG_LAST = 32'h0000_AFFF,
    parameter logic [31:0] VEC_FIRST = 32'h0000_0004,
    parameter logic [31:0] VEC_LAST  = 32'h0000_00FF,
    parameter logic [31:0] SP_FLOOR  = 32'h0000_0800
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc_rd,
    input  logic           acc_wr,
    input  logic           acc_word,
    input  logic           acc_pspace,
    input  logic [AW-1:0]  acc_addr,
    input  logic           mac_op,
    input  logic           mac_ysel,
    input  logic           fetch_valid,
    input  logic [AW-1:0]  fetch_addr,
    input  logic           pc_load,
    input  logic [AW-1:0]  pc_target,
    input  logic           sp_load,
    input  logic [SPW-1:0] sp_value,
    input  logic           lim_wr,
    input  logic [SPW-1:0] lim_data,
    output logic           addr_err,
    output logic           stack_err
);
    logic data_fault;
    logic fetch_fault;
    logic sp_fault;

    afd_data_chk #(
        .AW(AW), .DATA_LAST(DATA_LAST), .Y_FIRST(Y_FIRST), .PROG_LAST(PROG_LAST)
    ) u_data (
        .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_word(acc_word),
        .acc_pspace(acc_pspace), .mac_op(mac_op), .mac_ysel(mac_ysel),
        .acc_addr(acc_addr), .fault(data_fault)
    );

    afd_fetch_fsm #(
        .AW(AW), .PROG_LAST(PROG_LAST), .VEC_FIRST(VEC_FIRST), .VEC_LAST(VEC_LAST)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .pc_load(pc_load), .pc_target(pc_target), .fault(fetch_fault)
    );

    afd_stack_chk #(
        .SPW(SPW), .SP_FLOOR(SP_FLOOR)
    ) u_stack (
        .clk(clk), .rst_n(rst_n), .lim_wr(lim_wr), .lim_data(lim_data),
        .sp_load(sp_load), .sp_value(sp_value), .fault(sp_fault)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_err  <= 1'b0;
            stack_err <= 1'b0;
        end else begin
            addr_err  <= data_fault | fetch_fault;
            stack_err <= sp_fault;
        end
    end
endmodule

// File: rtl/mem_fault_det_sva.sv
module mem_fault_det_sva #(
    parameter int          AW        = 24,
    parameter int          SPW       = 16,
    parameter logic [31:0] DATA_LAST = 32'h0000_1FFF,
    parameter logic [31:0] VEC_FIRST = 32'h0000_0004,
    parameter logic [31:0] VEC_LAST  = 32'h0000_00FF,
    parameter logic [31:0] SP_FLOOR  = 32'h0000_0800
) (
    input logic           clk,
    input logic           rst_n,
    input logic           acc_rd,
    input logic           acc_wr,
    input logic           acc_word,
    input logic           acc_pspace,
    input logic [AW-1:0]  acc_addr,
    input logic           mac_op,
    input logic           fetch_valid,
    input logic [AW-1:0]  fetch_addr,
    input logic           sp_load,
    input logic [SPW-1:0] sp_value,
    input logic           addr_err,
    input logic           stack_err
);
    a_r1_odd_word: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_rd || acc_wr) && acc_word && acc_addr[0]) |=> addr_err);

    a_r2_data_range: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_rd || acc_wr) && !acc_pspace && !mac_op && (acc_addr > DATA_LAST[AW-1:0]))
        |=> addr_err);

    a_r4_vector_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && (fetch_addr >= VEC_FIRST[AW-1:0]) && (fetch_addr <= VEC_LAST[AW-1:0]))
        |=> addr_err);

    a_r7_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_load && (sp_value < SP_FLOOR[SPW-1:0])) |=> stack_err);

    a_r10_stack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_load |=> !stack_err);

    a_r10_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rd && !acc_wr && !fetch_valid) |=> !addr_err);
endmodule

bind mem_fault_det mem_fault_det_sva #(
    .AW(AW), .SPW(SPW), .DATA_LAST(DATA_LAST),
    .VEC_FIRST(VEC_FIRST), .VEC_LAST(VEC_LAST), .SP_FLOOR(SP_FLOOR)
) u_sva (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_word(acc_word), .acc_pspace(acc_pspace), .acc_addr(acc_addr),
    .mac_op(mac_op), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .sp_load(sp_load), .sp_value(sp_value),
    .addr_err(addr_err), .stack_err(stack_err)
);

// File: tb/mem_fault_det_test.sv
module mem_fault_det_test;
    localparam int AW  = 24;
    localparam int SPW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           acc_rd = 0, acc_wr = 0, acc_word = 0, acc_pspace = 0;
    logic [AW-1:0]  acc_addr = '0;
    logic           mac_op = 0, mac_ysel = 0;
    logic           fetch_valid = 0;
    logic [AW-1:0]  fetch_addr = '0;
    logic           pc_load = 0;
    logic [AW-1:0]  pc_target = '0;
    logic           sp_load = 0;
    logic [SPW-1:0] sp_value = '0;
    logic           lim_wr = 0;
    logic [SPW-1:0] lim_data = '0;
    logic           addr_err, stack_err;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    mem_fault_det uut (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_word(acc_word), .acc_pspace(acc_pspace), .acc_addr(acc_addr),
        .mac_op(mac_op), .mac_ysel(mac_ysel), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .pc_load(pc_load), .pc_target(pc_target),
        .sp_load(sp_load), .sp_value(sp_value), .lim_wr(lim_wr),
        .lim_data(lim_data), .addr_err(addr_err), .stack_err(stack_err)
    );

    task automatic check(input string req, input logic got, input logic exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic clear_inputs();
        acc_rd = 0; acc_wr = 0; acc_word = 0; acc_pspace = 0; acc_addr = '0;
        mac_op = 0; mac_ysel = 0; fetch_valid = 0; fetch_addr = '0;
        pc_load = 0; pc_target = '0; sp_load = 0; sp_value = '0;
        lim_wr = 0; lim_data = '0;
    endtask

    // Inputs set before call are captured at the next edge; flags read 1 ns later.
    task automatic step(input string req, input logic exp_a, input logic exp_s);
        @(posedge clk); #1;
        check({req, " addr_err"}, addr_err, exp_a);
        check({req, " stack_err"}, stack_err, exp_s);
        clear_inputs();
    endtask

    task automatic data_acc(input string req, input logic wr, input logic word,
                            input logic pspace, input logic mac, input logic ysel,
                            input logic [AW-1:0] addr, input logic exp);
        acc_rd = !wr; acc_wr = wr; acc_word = word; acc_pspace = pspace;
        mac_op = mac; mac_ysel = ysel; acc_addr = addr;
        step(req, exp, 1'b0);
    endtask

    task automatic fetch(input string req, input logic [AW-1:0] addr, input logic exp);
        fetch_valid = 1; fetch_addr = addr;
        step(req, exp, 1'b0);
    endtask

    task automatic sp_try(input string req, input logic [SPW-1:0] v, input logic exp);
        sp_load = 1; sp_value = v;
        step(req, 1'b0, exp);
    endtask

    task automatic t_reset();
        #1;
        check("R10 reset addr_err", addr_err, 1'b0);
        check("R10 reset stack_err", stack_err, 1'b0);
    endtask

    task automatic t_align();
        data_acc("R1 odd word write", 1, 1, 0, 0, 0, 24'h000101, 1);
        data_acc("R1 odd byte read", 0, 0, 0, 0, 0, 24'h000101, 0);
        data_acc("R1 even word read", 0, 1, 0, 0, 0, 24'h000100, 0);
        data_acc("R1 odd word in program space", 0, 1, 1, 0, 0, 24'h000301, 1);
    endtask

    task automatic t_data_range();
        data_acc("R2 last data byte", 0, 0, 0, 0, 0, 24'h001FFF, 0);
        data_acc("R2 one past data", 1, 0, 0, 0, 0, 24'h002000, 1);
        data_acc("R2 far above data", 0, 1, 0, 0, 0, 24'h800000, 1);
    endtask

    task automatic t_prog_range();
        data_acc("R3 last program word", 0, 1, 1, 0, 0, 24'h00AFFE, 0);
        data_acc("R3 one past program", 0, 0, 1, 0, 0, 24'h00B000, 1);
    endtask

    task automatic t_fetch();
        fetch("R4 reset slot", 24'h000000, 0);
        fetch("R4 first vector", 24'h000004, 1);
        fetch("R4 last vector", 24'h0000FF, 1);
        fetch("R4 first code", 24'h000100, 0);
        fetch("R4 past program", 24'h00B000, 1);
    endtask

    task automatic t_mac();
        data_acc("R5 X in X", 0, 1, 0, 1, 0, 24'h000FFE, 0);
        data_acc("R5 X into Y", 0, 1, 0, 1, 0, 24'h001000, 1);
        data_acc("R5 Y in Y", 0, 1, 0, 1, 1, 24'h001000, 0);
        data_acc("R5 Y into X", 0, 1, 0, 1, 1, 24'h000FFE, 1);
        data_acc("R5 Y past data", 0, 1, 0, 1, 1, 24'h002000, 1);
    endtask

    task automatic t_stack();
        sp_try("R7 at floor", 16'h0800, 0);
        sp_try("R7 below floor", 16'h07FE, 1);
        sp_try("R8 reset limit no overflow", 16'hFFFF, 0);
        lim_wr = 1; lim_data = 16'h1000;
        step("R8 limit write", 1'b0, 1'b0);
        sp_try("R6 equal to limit", 16'h1000, 0);
        sp_try("R6 above limit", 16'h1002, 1);
        sp_try("R8 old max now overflows", 16'hFFFF, 1);
    endtask

    task automatic t_pc_load();
        pc_load = 1; pc_target = 24'h00B000;
        step("R9 bad target no flag", 1'b0, 1'b0);
        fetch("R9 next fetch faults", 24'h000200, 1);
        fetch("R9 fault consumed", 24'h000200, 0);
        pc_load = 1; pc_target = 24'h00C000;
        step("R9 second bad target", 1'b0, 1'b0);
        pc_load = 1; pc_target = 24'h000300;
        step("R9 good target cancels", 1'b0, 1'b0);
        fetch("R9 fetch after cancel", 24'h000300, 0);
    endtask

    task automatic t_pulse();
        data_acc("R10 fault cycle", 1, 1, 0, 0, 0, 24'h000003, 1);
        step("R10 idle after fault", 1'b0, 1'b0);
        sp_try("R10 stack fault cycle", 16'h0000, 1);
        step("R10 idle after stack fault", 1'b0, 1'b0);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        step("R10 idle after reset", 1'b0, 1'b0);
        t_align();
        t_data_range();
        t_prog_range();
        t_fetch();
        t_mac();
        t_stack();
        t_pc_load();
        t_pulse();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule